// File: doc/BRIEF.md
# Packet-Gating Stream FIFO

This block is a single-clock synchronous FIFO placed between two AXI4-Stream interfaces. Every accepted beat is stored as one entry holding its data word, its user sideband and its end-of-packet marker, and the same three fields come back together on the read side. Writes are accepted whenever space remains, and beats leave in the order they arrived.

A build-time mode chooses how stored beats are released. In stream mode a beat can be read on the cycle after it is accepted. In packet mode the read side stays silent until a whole packet, closed by a TLAST beat, sits in the buffer. A running count of completed packets gates the output. While one finished packet drains, the write side keeps taking the next packet. A packet that fills the whole buffer without a TLAST can never be released, so the block flags it as oversize. The fill level and the full and empty states are exported.

Top module: `axis_pkt_fifo`

## Requirements
- R1: The TUSER and TLAST values of a beat are presented on the read side together with that beat's TDATA.
- R2: In stream mode (MODE = FIFO_STREAM), m_tvalid_o is high on the cycle after a beat is accepted into an empty FIFO, and stays high while any beat is stored.
- R3: In packet mode (MODE = FIFO_PACKET), m_tvalid_o stays low while no stored beat carries TLAST = 1, and rises on the cycle after a TLAST = 1 beat is accepted.
- R4: In packet mode, s_tready_o stays high while a completed packet is being read out, provided space remains, and the next packet is withheld until its own TLAST beat is stored.
- R5: level_o equals the number of stored beats; a cycle with both a write and a read leaves it unchanged.
- R6: When DEPTH beats are stored, full_o is high and s_tready_o is low; a write offered then is ignored and no stored beat is overwritten.
- R7: empty_o is high exactly when no beat is stored, and m_tvalid_o is low whenever empty_o is high.
- R8: oversize_o is high in packet mode when the FIFO is full and no stored beat carries TLAST = 1; it is always low in stream mode.
- R9: After reset, level_o is 0, empty_o is 1, full_o is 0, s_tready_o is 1, m_tvalid_o is 0 and oversize_o is 0.
- R10: Beats leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_tdata_i | input | DATA_W | Write-side data |
| s_tuser_i | input | USER_W | Write-side user sideband |
| s_tlast_i | input | 1 | Write-side end-of-packet |
| s_tvalid_i | input | 1 | Write-side valid |
| s_tready_o | output | 1 | Write-side ready, low when full |
| m_tdata_o | output | DATA_W | Read-side data |
| m_tuser_o | output | USER_W | Read-side user sideband |
| m_tlast_o | output | 1 | Read-side end-of-packet |
| m_tvalid_o | output | 1 | Read-side valid |
| m_tready_i | input | 1 | Read-side ready |
| level_o | output | $clog2(DEPTH)+1 | Stored beat count |
| full_o | output | 1 | DEPTH beats stored |
| empty_o | output | 1 | No beat stored |
| oversize_o | output | 1 | Packet mode: full with no TLAST stored |

## Verification
A pointer that slips shows on the very next cycle as a wrong level_o or flag, and as a read word that is out of order or repeated on the first pop after it. If the completed-packet count drifts, m_tvalid_o is wrong on the cycle after the TLAST beat that caused the drift. The opposite drift either releases a partial packet early or freezes the read side for good. A wrong full decision shows at once as a surplus write accepted, and the beat that write destroyed comes out wrong when the buffer is later drained.

// File: rtl/axis_pkt_fifo_pkg.sv
package axis_pkt_fifo_pkg;

  typedef enum logic {
    FIFO_STREAM = 1'b0,
    FIFO_PACKET = 1'b1
  } fifo_mode_e;

endpackage

// File: rtl/axis_pkt_fifo_ptrs.sv
module axis_pkt_fifo_ptrs #(
  parameter int DEPTH = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic                       pop_i,
  output logic [$clog2(DEPTH)-1:0]   wr_addr_o,
  output logic [$clog2(DEPTH)-1:0]   rd_addr_o,
  output logic [$clog2(DEPTH):0]     level_o,
  output logic                       full_o,
  output logic                       empty_o
);
  localparam int AW = $clog2(DEPTH);

  // one extra wrap bit separates full from empty
  logic [AW:0] wr_ptr_q, rd_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + (AW+1)'(1);
      if (pop_i)  rd_ptr_q <= rd_ptr_q + (AW+1)'(1);
    end
  end

  assign wr_addr_o = wr_ptr_q[AW-1:0];
  assign rd_addr_o = rd_ptr_q[AW-1:0];
  assign level_o   = wr_ptr_q - rd_ptr_q;
  assign empty_o   = (wr_ptr_q == rd_ptr_q);
  assign full_o    = (wr_ptr_q[AW] != rd_ptr_q[AW]) &&
                     (wr_ptr_q[AW-1:0] == rd_ptr_q[AW-1:0]);

endmodule

// File: rtl/axis_pkt_fifo_ram.sv
module axis_pkt_fifo_ram #(
  parameter int W     = 19,
  parameter int DEPTH = 32
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [W-1:0]             wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [W-1:0]             rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // fall-through read: head entry visible without a pop cycle
  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/axis_pkt_fifo_gate.sv
module axis_pkt_fifo_gate
  import axis_pkt_fifo_pkg::*;
#(
  parameter int         DEPTH = 32,
  parameter fifo_mode_e MODE  = FIFO_PACKET
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       last_in_i,
  input  logic                       last_out_i,
  input  logic                       full_i,
  output logic [$clog2(DEPTH+1)-1:0] pkt_cnt_o,
  output logic                       release_o,
  output logic                       oversize_o
);
  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (last_in_i && !last_out_i) begin
      cnt_q <= cnt_q + CW'(1);
    end else if (!last_in_i && last_out_i) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign pkt_cnt_o = cnt_q;

  if (MODE == FIFO_PACKET) begin : g_packet
    assign release_o  = (cnt_q != '0);
    assign oversize_o = full_i && (cnt_q == '0);
  end else begin : g_stream
    logic unused_full;
    assign unused_full = full_i;
    assign release_o   = 1'b1;
    assign oversize_o  = 1'b0;
  end

endmodule

// File: rtl/axis_pkt_fifo.sv
module axis_pkt_fifo
  import axis_pkt_fifo_pkg::*;
#(
  parameter int         DATA_W = 16,
  parameter int         USER_W = 2,
  parameter int         DEPTH  = 32,
  parameter fifo_mode_e MODE   = FIFO_PACKET
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [DATA_W-1:0]        s_tdata_i,
  input  logic [USER_W-1:0]        s_tuser_i,
  input  logic                     s_tlast_i,
  input  logic                     s_tvalid_i,
  output logic                     s_tready_o,
  output logic [DATA_W-1:0]        m_tdata_o,
  output logic [USER_W-1:0]        m_tuser_o,
  output logic                     m_tlast_o,
  output logic                     m_tvalid_o,
  input  logic                     m_tready_i,
  output logic [$clog2(DEPTH):0]   level_o,
  output logic                     full_o,
  output logic                     empty_o,
  output logic                     oversize_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = USER_W + 1 + DATA_W;
  localparam int CW = $clog2(DEPTH+1);

  if (DEPTH < 2 || DEPTH != (1 << AW)) begin : g_bad_depth
    $error("axis_pkt_fifo: DEPTH must be a power of two of at least 2");
  end

  logic          push, pop, pkt_release;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [EW-1:0] wr_entry, rd_entry;
  logic [CW-1:0] pkt_cnt;

  assign s_tready_o = !full_o;
  assign push       = s_tvalid_i && !full_o;
  assign m_tvalid_o = !empty_o && pkt_release;
  assign pop        = m_tvalid_o && m_tready_i;

  assign wr_entry = {s_tuser_i, s_tlast_i, s_tdata_i};
  assign {m_tuser_o, m_tlast_o, m_tdata_o} = rd_entry;

  axis_pkt_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push),
    .pop_i     (pop),
    .wr_addr_o (wr_addr),
    .rd_addr_o (rd_addr),
    .level_o   (level_o),
    .full_o    (full_o),
    .empty_o   (empty_o)
  );

  axis_pkt_fifo_ram #(.W(EW), .DEPTH(DEPTH)) u_ram (
    .clk_i   (clk_i),
    .we_i    (push),
    .waddr_i (wr_addr),
    .wdata_i (wr_entry),
    .raddr_i (rd_addr),
    .rdata_o (rd_entry)
  );

  axis_pkt_fifo_gate #(.DEPTH(DEPTH), .MODE(MODE)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .last_in_i  (push && s_tlast_i),
    .last_out_i (pop && m_tlast_o),
    .full_i     (full_o),
    .pkt_cnt_o  (pkt_cnt),
    .release_o  (pkt_release),
    .oversize_o (oversize_o)
  );

endmodule

// File: rtl/axis_pkt_fifo_chk.sv
module axis_pkt_fifo_chk
  import axis_pkt_fifo_pkg::*;
#(
  parameter int         DATA_W = 16,
  parameter int         USER_W = 2,
  parameter int         DEPTH  = 32,
  parameter fifo_mode_e MODE   = FIFO_PACKET
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       s_tvalid_i,
  input logic                       s_tready_o,
  input logic [DATA_W-1:0]          m_tdata_o,
  input logic [USER_W-1:0]          m_tuser_o,
  input logic                       m_tlast_o,
  input logic                       m_tvalid_o,
  input logic                       m_tready_i,
  input logic [$clog2(DEPTH):0]     level_o,
  input logic                       full_o,
  input logic                       empty_o,
  input logic                       oversize_o,
  input logic [$clog2(DEPTH+1)-1:0] pkt_cnt
);
  logic seen_q;
  logic wr_fire, rd_fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assign wr_fire = s_tvalid_i && s_tready_o;
  assign rd_fire = m_tvalid_o && m_tready_i;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !s_tready_o); // R6

  AST_LEVEL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (int'(level_o) == int'($past(level_o)) + int'($past(wr_fire)) - int'($past(rd_fire)))); // R5

  AST_LEVEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(level_o) <= DEPTH); // R5

  AST_HOLD_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_o && !m_tready_i) |=> (m_tvalid_o && $stable({m_tuser_o, m_tlast_o, m_tdata_o}))); // R1

  AST_EMPTY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (!m_tvalid_o && level_o == '0)); // R7

  AST_PKT_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE == FIFO_PACKET && pkt_cnt == '0) |-> !m_tvalid_o); // R3

  AST_OVERSIZE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oversize_o |-> full_o); // R8

endmodule

bind axis_pkt_fifo axis_pkt_fifo_chk #(
  .DATA_W (DATA_W),
  .USER_W (USER_W),
  .DEPTH  (DEPTH),
  .MODE   (MODE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .s_tvalid_i (s_tvalid_i),
  .s_tready_o (s_tready_o),
  .m_tdata_o  (m_tdata_o),
  .m_tuser_o  (m_tuser_o),
  .m_tlast_o  (m_tlast_o),
  .m_tvalid_o (m_tvalid_o),
  .m_tready_i (m_tready_i),
  .level_o    (level_o),
  .full_o     (full_o),
  .empty_o    (empty_o),
  .oversize_o (oversize_o),
  .pkt_cnt    (pkt_cnt)
);

// File: tb/tb_axis_pkt_fifo.sv
module tb_axis_pkt_fifo;
  import axis_pkt_fifo_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int LW         = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] s_tdata = '0;
  logic       s_tuser = 1'b0;
  logic       s_tlast = 1'b0;
  logic       s_tvalid = 1'b0;
  logic       rdy_p = 1'b0, rdy_n = 1'b0;

  logic          tr_p, tv_p, last_p, user_p, full_p, empty_p, ov_p;
  logic [7:0]    data_p;
  logic [LW-1:0] lvl_p;
  logic          tr_n, tv_n, last_n, user_n, full_n, empty_n, ov_n;
  logic [7:0]    data_n;
  logic [LW-1:0] lvl_n;

  int n_cmp = 0;
  int n_bad = 0;
  logic [9:0] q_p[$];
  logic [9:0] q_n[$];
  logic smp_tv_p, smp_tr_p, smp_ov_p, smp_ov_n;
  int   smp_lvl_p;

  always #(CLK_PERIOD/2) clk = ~clk;

  axis_pkt_fifo #(.DATA_W(8), .USER_W(1), .DEPTH(DEPTH), .MODE(FIFO_PACKET)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .s_tdata_i(s_tdata), .s_tuser_i(s_tuser), .s_tlast_i(s_tlast),
    .s_tvalid_i(s_tvalid), .s_tready_o(tr_p),
    .m_tdata_o(data_p), .m_tuser_o(user_p), .m_tlast_o(last_p),
    .m_tvalid_o(tv_p), .m_tready_i(rdy_p),
    .level_o(lvl_p), .full_o(full_p), .empty_o(empty_p), .oversize_o(ov_p)
  );

  axis_pkt_fifo #(.DATA_W(8), .USER_W(1), .DEPTH(DEPTH), .MODE(FIFO_STREAM)) dut_norm (
    .clk_i(clk), .rst_ni(rst_ni),
    .s_tdata_i(s_tdata), .s_tuser_i(s_tuser), .s_tlast_i(s_tlast),
    .s_tvalid_i(s_tvalid), .s_tready_o(tr_n),
    .m_tdata_o(data_n), .m_tuser_o(user_n), .m_tlast_o(last_n),
    .m_tvalid_o(tv_n), .m_tready_i(rdy_n),
    .level_o(lvl_n), .full_o(full_n), .empty_o(empty_n), .oversize_o(ov_n)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int nlast(logic [9:0] q[$]);
    int n = 0;
    foreach (q[i]) if (q[i][8]) n++;
    return n;
  endfunction

  // compare one instance against the model: beat = {user, last, data}
  task automatic check_one(string nm, bit pkt, int sz, int nl, logic [9:0] head,
                           logic tv, logic tr, int lvl, logic fu, logic em,
                           logic ov, logic [9:0] ob);
    bit exp_tv = (sz > 0) && (!pkt || nl > 0);
    chk(pkt ? "R3" : "R2", {nm, " m_tvalid"}, int'(tv), int'(exp_tv));
    chk("R5", {nm, " level"}, lvl, sz);
    chk("R6", {nm, " s_tready"}, int'(tr), int'(sz < DEPTH));
    chk("R6", {nm, " full"}, int'(fu), int'(sz == DEPTH));
    chk("R7", {nm, " empty"}, int'(em), int'(sz == 0));
    chk("R8", {nm, " oversize"}, int'(ov), int'(pkt && sz == DEPTH && nl == 0));
    if (exp_tv && tv) begin
      chk("R10", {nm, " head data"}, int'(ob[7:0]), int'(head[7:0]));
      chk("R1", {nm, " head user/last"}, int'(ob[9:8]), int'(head[9:8]));
    end
  endtask

  task automatic cyc(bit wv, logic [7:0] d, bit u, bit l, bit rn, bit rp);
    bit tvp, tvn, wp, wn;
    @(negedge clk);
    s_tvalid = wv; s_tdata = d; s_tuser = u; s_tlast = l;
    rdy_p = rp; rdy_n = rn;
    #1;
    check_one("pkt", 1'b1, q_p.size(), nlast(q_p), q_p.size() > 0 ? q_p[0] : 10'h0,
              tv_p, tr_p, int'(lvl_p), full_p, empty_p, ov_p, {user_p, last_p, data_p});
    check_one("stream", 1'b0, q_n.size(), nlast(q_n), q_n.size() > 0 ? q_n[0] : 10'h0,
              tv_n, tr_n, int'(lvl_n), full_n, empty_n, ov_n, {user_n, last_n, data_n});
    smp_tv_p = tv_p; smp_tr_p = tr_p; smp_ov_p = ov_p; smp_ov_n = ov_n;
    smp_lvl_p = int'(lvl_p);
    tvp = (q_p.size() > 0) && (nlast(q_p) > 0);
    tvn = (q_n.size() > 0);
    wp  = wv && (q_p.size() < DEPTH);
    wn  = wv && (q_n.size() < DEPTH);
    @(posedge clk);
    if (rp && tvp) void'(q_p.pop_front());
    if (rn && tvn) void'(q_n.pop_front());
    if (wp) q_p.push_back({u, l, d});
    if (wn) q_n.push_back({u, l, d});
  endtask

  task automatic idle();
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic drain();
    for (int i = 0; i < DEPTH + 2; i++) cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    s_tvalid = 1'b0; rdy_p = 1'b0; rdy_n = 1'b0;
    rst_ni = 1'b0;
    q_p.delete(); q_n.delete();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R9", "pkt level", int'(lvl_p), 0);
    chk("R9", "pkt empty", int'(empty_p), 1);
    chk("R9", "pkt full", int'(full_p), 0);
    chk("R9", "pkt s_tready", int'(tr_p), 1);
    chk("R9", "pkt m_tvalid", int'(tv_p), 0);
    chk("R9", "pkt oversize", int'(ov_p), 0);
    chk("R9", "stream m_tvalid", int'(tv_n), 0);
    chk("R9", "stream level", int'(lvl_n), 0);
  endtask

  task automatic t_mode_contrast();
    cyc(1'b1, 8'h11, 1'b1, 1'b0, 1'b0, 1'b0);
    idle();
    chk("R2", "stream valid after first beat", int'(tv_n), 1);
    chk("R3", "pkt held before TLAST", int'(smp_tv_p), 0);
    cyc(1'b1, 8'h12, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 8'h13, 1'b0, 1'b1, 1'b0, 1'b0);
    idle();
    chk("R3", "pkt released after TLAST", int'(smp_tv_p), 1);
    drain();
  endtask

  task automatic t_sideband_mix();
    for (int i = 0; i < 14; i++)
      cyc(1'b1, 8'(i * 7 + 3), (i % 3) == 0, (i % 2) == 1, (i % 4) != 0, (i % 3) != 1);
    drain();
  endtask

  task automatic t_overlap();
    for (int i = 0; i < 4; i++) cyc(1'b1, 8'(8'hA0 + i), 1'b0, i == 3, 1'b0, 1'b0);
    idle();
    for (int i = 0; i < 4; i++) begin
      cyc(1'b1, 8'(8'hB0 + i), 1'b0, 1'b0, 1'b1, 1'b1);
      chk("R4", "s_tready while draining", int'(smp_tr_p), 1);
      chk("R4", "pkt level during overlap", smp_lvl_p, 4);
    end
    idle();
    chk("R4", "second packet held", int'(smp_tv_p), 0);
    cyc(1'b1, 8'hB4, 1'b1, 1'b1, 1'b0, 1'b0);
    idle();
    chk("R4", "second packet released", int'(smp_tv_p), 1);
    drain();
  endtask

  task automatic t_full_oversize();
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, 8'(8'hC0 + i), 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 8'hEE, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R6", "pkt s_tready when full", int'(smp_tr_p), 0);
    chk("R6", "pkt level stays DEPTH", smp_lvl_p, DEPTH);
    chk("R8", "pkt oversize", int'(smp_ov_p), 1);
    chk("R8", "stream oversize", int'(smp_ov_n), 0);
    drain();
    do_reset();
    for (int i = 0; i < DEPTH; i++)
      cyc(1'b1, 8'(8'hD0 + i), i[0], i == DEPTH - 1, 1'b0, 1'b0);
    cyc(1'b1, 8'hEF, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8", "full with TLAST stored", int'(smp_ov_p), 0);
    chk("R6", "surplus write refused", int'(smp_tr_p), 0);
    drain();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_mode_contrast();
    t_sideband_mix();
    t_overlap();
    t_full_oversize();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule